// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Line-Break Recognition

This block is the receive front end of an asynchronous serial port. A free-running enable pulse, `os_tick`, comes at sixteen times the bit rate. On each pulse the block looks at the serial line. It confirms a start bit at the middle of that bit, then samples every later bit at its centre. It collects 5 to 8 data bits, least significant bit first, then an optional parity bit and one stop bit. At the stop-bit sample it delivers one word: the data byte plus three flags, parity error, framing error and break. The word comes out with a one-cycle `rx_valid` strobe, ready to be written into a downstream buffer. The block does not generate the bit rate, store words or provide a host bus.

A break is a line held low. When a break starts inside a frame, the block delivers that damaged frame with its framing-error flag set. It then watches the line for one more full frame time. If the line stays low for that whole time, it delivers a second word with zero data and the break flag set. A line that is low from the start bit through the stop bit gives one break word only. After any break word, the receiver waits for the line to return high before it looks for a new start bit.

The serial input `rx_in` must already be synchronous to `clk`. The configuration inputs may change only while the line is idle.

Top module: `uart_rx_brk`

## Requirements
- R1: On the first `os_tick` that sees `rx_in` low while idle, the receiver arms. It samples the line again 8 ticks later. If the line is high at that sample, the start is rejected, no word is produced and the receiver returns to idle.
- R2: `cfg_data_bits` selects the number of data bits: 0 = 5, 1 = 6, 2 = 7, 3 = 8. Data bits are received least significant bit first, one sample every 16 ticks at mid-bit. Bits of `rx_data` above the selected width are 0.
- R3: When `cfg_par_en` = 1, one parity bit follows the data. `cfg_par_odd` = 0 selects even parity and 1 selects odd parity. `rx_perr` = 1 when the data bits and the parity bit fail the selected rule. When `cfg_par_en` = 0 there is no parity bit and `rx_perr` is always 0.
- R4: A stop bit sampled low sets `rx_ferr` on that word, unless every sample of the frame was low (see R7).
- R5: A frame with at least one high sample and a low stop bit gives a framing-error word. If the next full frame time of samples (start + data + parity + stop) is all low, the block then delivers a second word with `rx_data` = 0, `rx_brk` = 1, `rx_ferr` = 0 and `rx_perr` = 0.
- R6: If any sample in the frame time after a framing-error word is high, no break word is produced.
- R7: A frame whose samples, from the start bit through the stop bit, are all low gives exactly one word: the break word.
- R8: After a break word, no start bit is accepted until `rx_in` has been seen high on an `os_tick`. A line held low after a break produces no more words.
- R9: `rx_valid` is high for exactly one `clk` cycle per word. It is registered and is asserted in the cycle after the `os_tick` edge that sampled the stop bit (or the last break-check bit). Data and flags are valid in that cycle and hold their values until the next word.
- R10: While `rst_n` is low and after reset, `rx_valid`, `rx_data` and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| os_tick | input | 1 | Enable pulse at 16x the bit rate |
| rx_in | input | 1 | Serial line, already synchronous to `clk`; idle high |
| cfg_data_bits | input | 2 | Data width select (0 = 5 bits … 3 = 8 bits) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| rx_valid | output | 1 | One-cycle strobe for a delivered word |
| rx_data | output | 8 | Received data, upper unused bits 0 |
| rx_perr | output | 1 | Parity error flag |
| rx_ferr | output | 1 | Framing error flag |
| rx_brk | output | 1 | Break flag |

## Verification
The bench drives a break that starts partway through a frame and lasts two frame times. A design that drops the damaged frame, or that forgets to report the break, would give one word where two are expected. It also drives a break that ends inside the check window; a design that declares a break too early would add a spurious break word. A line that is low from the start bit, and then stays low for a long time, must give one break word only. A receiver that hunts for a start bit straight after the break would instead produce a stream of zero words. A short low glitch, 5-bit frames sent with high upper bits, and both parity senses with a correct or a flipped parity bit expose these faults: a start accepted without checking mid-bit, data not masked to the selected width, and an inverted parity rule.

// File: rtl/uart_rx_pkg.sv
// Shared constants and types for the serial receiver.
// Assumes a fixed maximum character width of 8 bits.
package uart_rx_pkg;

    localparam int DATA_MAX = 8;
    localparam int MIN_BITS = 5;
    localparam int BCNT_W   = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_BRKCHK,
        ST_MARK
    } rx_state_e;

    typedef struct packed {
        logic [DATA_MAX-1:0] data;
        logic                perr;
        logic                ferr;
        logic                brk;
    } rx_word_t;

endpackage

// File: rtl/uart_rx_bitclk.sv
// Oversampling phase counter for the serial receiver.
// After a restart it produces one strobe on the (OS_RATE/2)th tick
// (the middle of the start bit), then one strobe every OS_RATE ticks.
// Assumes os_tick is a single-cycle enable; OS_RATE is even and >= 4.
module uart_rx_bitclk #(
    parameter int OS_RATE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic os_tick,
    input  logic restart,
    output logic strobe
);
    localparam int CW       = $clog2(OS_RATE);
    localparam int HALF_LIM = OS_RATE / 2 - 1;
    localparam int FULL_LIM = OS_RATE - 1;

    logic [CW-1:0] cnt_q;
    logic          half_q;
    logic [CW-1:0] limit;

    // Pick the terminal count for the current phase (half bit or full bit).
    always_comb begin
        limit = half_q ? CW'(HALF_LIM) : CW'(FULL_LIM);
    end

    assign strobe = os_tick && (cnt_q == limit);

    // Advance the tick counter and leave half-bit mode after the first strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            half_q <= 1'b1;
        end else if (restart) begin
            cnt_q  <= '0;
            half_q <= 1'b1;
        end else if (os_tick) begin
            if (cnt_q == limit) begin
                cnt_q  <= '0;
                half_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/uart_rx_flags.sv
// Data masking and parity evaluation for a completed character.
// Assumes shift-register bits above the configured width may hold anything;
// they are masked off here before parity is computed.
module uart_rx_flags
    import uart_rx_pkg::*;
(
    input  logic [DATA_MAX-1:0] shreg,
    input  logic [1:0]          width_sel,
    input  logic                par_bit,
    input  logic                par_en,
    input  logic                par_odd,
    output logic [DATA_MAX-1:0] data_out,
    output logic                perr
);
    logic [DATA_MAX-1:0] mask;
    logic [BCNT_W-1:0]   nbits;

    assign nbits = BCNT_W'(width_sel) + BCNT_W'(MIN_BITS);

    // Build the per-bit keep mask from the configured data width.
    for (genvar i = 0; i < DATA_MAX; i++) begin : g_mask
        assign mask[i] = (BCNT_W'(i) < nbits);
    end

    assign data_out = shreg & mask;

    // Parity error: data plus parity bit must have even weight (even) or odd weight (odd).
    always_comb begin
        perr = par_en && ((^data_out) ^ par_bit ^ par_odd);
    end

endmodule

// File: rtl/uart_rx_ctrl.sv
// Frame sequencer of the serial receiver: start validation, data/parity/stop
// sampling, framing error and break recognition, including a break that
// begins inside a character. Emits one word per delivered entry.
// Assumes strobe marks mid-bit samples and that configuration is stable per frame.
module uart_rx_ctrl
    import uart_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       os_tick,
    input  logic       rx,
    input  logic       strobe,
    input  logic [1:0] width_sel,
    input  logic       par_en,
    input  logic       par_odd,
    output logic       restart,
    output logic       emit,
    output rx_word_t   word
);
    rx_state_e           st_q, st_n;
    logic [BCNT_W-1:0]   bit_q, bit_n;
    logic [DATA_MAX-1:0] sh_q, sh_n;
    logic                par_q, par_n;
    logic                zero_q, zero_n;
    logic [DATA_MAX-1:0] data_m;
    logic                perr_c;
    logic [BCNT_W-1:0]   nbits;
    logic [BCNT_W-1:0]   flen;

    assign nbits = BCNT_W'(width_sel) + BCNT_W'(MIN_BITS);
    assign flen  = nbits + BCNT_W'(par_en) + BCNT_W'(2);

    uart_rx_flags flags_i (
        .shreg     (sh_q),
        .width_sel (width_sel),
        .par_bit   (par_q),
        .par_en    (par_en),
        .par_odd   (par_odd),
        .data_out  (data_m),
        .perr      (perr_c)
    );

    // Next-state, sampling and word-emission logic of the frame sequencer.
    always_comb begin
        st_n    = st_q;
        bit_n   = bit_q;
        sh_n    = sh_q;
        par_n   = par_q;
        zero_n  = zero_q;
        restart = 1'b0;
        emit    = 1'b0;
        word    = '0;
        case (st_q)
            ST_IDLE: begin
                if (os_tick && !rx) begin
                    restart = 1'b1;
                    st_n    = ST_START;
                end
            end
            ST_START: begin
                if (strobe) begin
                    if (!rx) begin
                        st_n   = ST_DATA;
                        bit_n  = '0;
                        sh_n   = '0;
                        par_n  = 1'b0;
                        zero_n = 1'b1;
                    end else begin
                        st_n = ST_IDLE;
                    end
                end
            end
            ST_DATA: begin
                if (strobe) begin
                    sh_n[bit_q[2:0]] = rx;
                    zero_n           = zero_q && !rx;
                    if (bit_q == nbits - 1'b1) begin
                        bit_n = '0;
                        st_n  = par_en ? ST_PAR : ST_STOP;
                    end else begin
                        bit_n = bit_q + 1'b1;
                    end
                end
            end
            ST_PAR: begin
                if (strobe) begin
                    par_n  = rx;
                    zero_n = zero_q && !rx;
                    st_n   = ST_STOP;
                end
            end
            ST_STOP: begin
                if (strobe) begin
                    emit = 1'b1;
                    if (rx) begin
                        word.data = data_m;
                        word.perr = perr_c;
                        st_n      = ST_IDLE;
                    end else if (zero_q) begin
                        word.brk = 1'b1;
                        st_n     = ST_MARK;
                    end else begin
                        word.data = data_m;
                        word.perr = perr_c;
                        word.ferr = 1'b1;
                        bit_n     = '0;
                        st_n      = ST_BRKCHK;
                    end
                end
            end
            ST_BRKCHK: begin
                if (strobe) begin
                    if (rx) begin
                        st_n = ST_IDLE;
                    end else if (bit_q == flen - 1'b1) begin
                        emit     = 1'b1;
                        word.brk = 1'b1;
                        st_n     = ST_MARK;
                    end else begin
                        bit_n = bit_q + 1'b1;
                    end
                end
            end
            ST_MARK: begin
                if (os_tick && rx) begin
                    st_n = ST_IDLE;
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    // State and datapath registers of the frame sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            bit_q  <= '0;
            sh_q   <= '0;
            par_q  <= 1'b0;
            zero_q <= 1'b0;
        end else begin
            st_q   <= st_n;
            bit_q  <= bit_n;
            sh_q   <= sh_n;
            par_q  <= par_n;
            zero_q <= zero_n;
        end
    end

endmodule

// File: rtl/uart_rx_brk.sv
// Top of the asynchronous serial receiver with break recognition.
// Assumes rx_in is already synchronous to clk and os_tick runs at 16x the bit rate.
// Output word and strobe are registered; the word holds until the next delivery.
module uart_rx_brk
    import uart_rx_pkg::*;
#(
    parameter int OS_RATE = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                os_tick,
    input  logic                rx_in,
    input  logic [1:0]          cfg_data_bits,
    input  logic                cfg_par_en,
    input  logic                cfg_par_odd,
    output logic                rx_valid,
    output logic [DATA_MAX-1:0] rx_data,
    output logic                rx_perr,
    output logic                rx_ferr,
    output logic                rx_brk
);
    logic     strobe;
    logic     restart;
    logic     emit;
    rx_word_t word;
    rx_word_t word_q;

    uart_rx_bitclk #(.OS_RATE(OS_RATE)) bitclk_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .os_tick (os_tick),
        .restart (restart),
        .strobe  (strobe)
    );

    uart_rx_ctrl ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .os_tick   (os_tick),
        .rx        (rx_in),
        .strobe    (strobe),
        .width_sel (cfg_data_bits),
        .par_en    (cfg_par_en),
        .par_odd   (cfg_par_odd),
        .restart   (restart),
        .emit      (emit),
        .word      (word)
    );

    // Register the delivered word and its one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_valid <= 1'b0;
            word_q   <= '0;
        end else begin
            rx_valid <= emit;
            if (emit) begin
                word_q <= word;
            end
        end
    end

    assign rx_data = word_q.data;
    assign rx_perr = word_q.perr;
    assign rx_ferr = word_q.ferr;
    assign rx_brk  = word_q.brk;

endmodule

// File: rtl/uart_rx_brk_chk.sv
// Property checker for uart_rx_brk, attached with bind.
module uart_rx_brk_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       os_tick,
    input logic       rx_in,
    input logic [1:0] cfg_data_bits,
    input logic       cfg_par_en,
    input logic       rx_valid,
    input logic [7:0] rx_data,
    input logic       rx_perr,
    input logic       rx_ferr,
    input logic       rx_brk
);
    assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    assert_tick_aligned_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(os_tick));

    assert_brk_word_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_brk) |-> (rx_data == 8'h00 && !rx_ferr && !rx_perr));

    assert_brk_line_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_brk) |-> !$past(rx_in));

    assert_ferr_line_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ferr) |-> !$past(rx_in));

    assert_no_perr_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !cfg_par_en) |-> !rx_perr);

    assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && cfg_data_bits == 2'd0) |-> (rx_data[7:5] == 3'b000));

endmodule

bind uart_rx_brk uart_rx_brk_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .os_tick       (os_tick),
    .rx_in         (rx_in),
    .cfg_data_bits (cfg_data_bits),
    .cfg_par_en    (cfg_par_en),
    .rx_valid      (rx_valid),
    .rx_data       (rx_data),
    .rx_perr       (rx_perr),
    .rx_ferr       (rx_ferr),
    .rx_brk        (rx_brk)
);

// File: tb/uart_rx_brk_tb_top.sv
module uart_rx_brk_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b0;
    logic       rx_in = 1'b1;
    logic [1:0] cfg_data_bits = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       rx_valid;
    logic [7:0] rx_data;
    logic       rx_perr, rx_ferr, rx_brk;

    int checks = 0;
    int errors = 0;
    int tdiv = 0;

    always #10 clk = ~clk;

    uart_rx_brk dut_i (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_in(rx_in),
        .cfg_data_bits(cfg_data_bits), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_perr(rx_perr),
        .rx_ferr(rx_ferr), .rx_brk(rx_brk)
    );

    // oversampling enable: one clock in four
    always @(negedge clk) begin
        tdiv = (tdiv + 1) % 4;
        os_tick = (tdiv == 3);
    end

    // ---------------- behavioural reference model ----------------
    localparam int M_IDLE = 0, M_START = 1, M_DATA = 2, M_PAR = 3,
                   M_STOP = 4, M_CHK = 5, M_MARK = 6;
    int m_st = M_IDLE, m_cnt = 0, m_bit = 0, m_data = 0, m_par = 0;
    bit m_half = 1, m_zero = 0;
    bit e_valid = 0, e_perr = 0, e_ferr = 0, e_brk = 0;
    int e_data = 0;

    always @(posedge clk) begin
        int  nb, fl, lim;
        bit  smp, rst_c, pe;
        if (!rst_n) begin
            m_st = M_IDLE; m_cnt = 0; m_half = 1; m_bit = 0; m_data = 0; m_par = 0; m_zero = 0;
            e_valid = 0; e_data = 0; e_perr = 0; e_ferr = 0; e_brk = 0;
        end else begin
            nb  = 5 + cfg_data_bits;
            fl  = nb + cfg_par_en + 2;
            lim = m_half ? 7 : 15;
            smp = os_tick && (m_cnt == lim);
            rst_c = (m_st == M_IDLE) && os_tick && !rx_in;
            if (rst_c) begin m_cnt = 0; m_half = 1; end
            else if (os_tick) begin
                if (m_cnt == lim) begin m_cnt = 0; m_half = 0; end
                else m_cnt++;
            end
            pe = 0;
            if (cfg_par_en) begin
                pe = cfg_par_odd;
                for (int i = 0; i < 8; i++) pe = pe ^ m_data[i];
                pe = pe ^ m_par[0];
            end
            e_valid = 0;
            case (m_st)
                M_IDLE:  if (rst_c) m_st = M_START;
                M_START: if (smp) begin
                    if (!rx_in) begin m_st = M_DATA; m_bit = 0; m_data = 0; m_par = 0; m_zero = 1; end
                    else m_st = M_IDLE;
                end
                M_DATA: if (smp) begin
                    if (rx_in) begin m_data = m_data | (1 << m_bit); m_zero = 0; end
                    if (m_bit == nb - 1) begin m_bit = 0; m_st = cfg_par_en ? M_PAR : M_STOP; end
                    else m_bit++;
                end
                M_PAR: if (smp) begin
                    m_par = rx_in; if (rx_in) m_zero = 0; m_st = M_STOP;
                end
                M_STOP: if (smp) begin
                    e_valid = 1;
                    if (rx_in) begin
                        e_data = m_data; e_perr = pe; e_ferr = 0; e_brk = 0; m_st = M_IDLE;
                    end else if (m_zero) begin
                        e_data = 0; e_perr = 0; e_ferr = 0; e_brk = 1; m_st = M_MARK;
                    end else begin
                        e_data = m_data; e_perr = pe; e_ferr = 1; e_brk = 0; m_bit = 0; m_st = M_CHK;
                    end
                end
                M_CHK: if (smp) begin
                    if (rx_in) m_st = M_IDLE;
                    else if (m_bit == fl - 1) begin
                        e_valid = 1; e_data = 0; e_perr = 0; e_ferr = 0; e_brk = 1; m_st = M_MARK;
                    end else m_bit++;
                end
                M_MARK: if (os_tick && rx_in) m_st = M_IDLE;
                default: m_st = M_IDLE;
            endcase
        end
    end

    // per-cycle comparison against the model (R9: strobe timing and held word)
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (rx_valid !== e_valid || rx_data !== 8'(e_data) || rx_perr !== e_perr ||
                rx_ferr !== e_ferr || rx_brk !== e_brk) begin
                errors++;
                $display("FAIL R9 model mismatch t=%0t: actual v=%0b d=%02h p=%0b f=%0b b=%0b expected v=%0b d=%02h p=%0b f=%0b b=%0b",
                         $time, rx_valid, rx_data, rx_perr, rx_ferr, rx_brk,
                         e_valid, 8'(e_data), e_perr, e_ferr, e_brk);
            end
        end
    end

    // capture delivered words: {data, perr, ferr, brk}
    logic [10:0] capq[$];
    always @(negedge clk) if (rst_n && rx_valid) capq.push_back({rx_data, rx_perr, rx_ferr, rx_brk});

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic hold(input logic v, input int bits);
        rx_in = v;
        repeat (bits * 64) @(negedge clk);
    endtask

    task automatic send_char(input logic [7:0] d, input int nb, input bit pflip, input logic stopv);
        logic p;
        p = cfg_par_odd;
        hold(1'b0, 1);
        for (int i = 0; i < nb; i++) begin
            p = p ^ d[i];
            hold(d[i], 1);
        end
        if (cfg_par_en) hold(p ^ pflip, 1);
        hold(stopv, 1);
    endtask

    task automatic set_cfg(input logic [1:0] w, input logic pen, input logic podd);
        cfg_data_bits = w; cfg_par_en = pen; cfg_par_odd = podd;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual running expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        // R10: reset state
        chk("R10 valid in reset", {31'd0, rx_valid}, 0);
        chk("R10 word in reset", {21'd0, rx_data, rx_perr, rx_ferr, rx_brk}, 0);
        rst_n = 1'b1;
        hold(1'b1, 2);
        chk("R10 word after reset", {20'd0, rx_valid, rx_data, rx_perr, rx_ferr, rx_brk}, 0);

        // R2/R9: 8-bit, no parity
        set_cfg(2'd3, 0, 0); capq.delete();
        send_char(8'hA5, 8, 0, 1'b1); hold(1'b1, 2);
        chk("R9 count 8N", capq.size(), 1);
        if (capq.size() > 0) chk("R2 8-bit word", capq[0], {8'hA5, 3'b000});

        // R2: 5-bit even parity, upper bits driven high must be zero
        set_cfg(2'd0, 1, 0); capq.delete();
        send_char(8'hF6, 5, 0, 1'b1); hold(1'b1, 2);
        chk("R2 count 5E", capq.size(), 1);
        if (capq.size() > 0) chk("R2 5-bit masked word", capq[0], {8'h16, 3'b000});

        // R3: 7-bit odd parity, flipped parity bit
        set_cfg(2'd2, 1, 1); capq.delete();
        send_char(8'h5B, 7, 1, 1'b1); hold(1'b1, 2);
        chk("R3 count 7O bad", capq.size(), 1);
        if (capq.size() > 0) chk("R3 odd parity error", capq[0], {8'h5B, 3'b100});

        // R3: 6-bit even parity, correct
        set_cfg(2'd1, 1, 0); capq.delete();
        send_char(8'h2D, 6, 0, 1'b1); hold(1'b1, 2);
        if (capq.size() > 0) chk("R3 even parity good", capq[0], {8'h2D, 3'b000});
        else chk("R3 count 6E", capq.size(), 1);

        // R3: 8-bit odd parity, zero data is not a break
        set_cfg(2'd3, 1, 1); capq.delete();
        send_char(8'h00, 8, 0, 1'b1); hold(1'b1, 2);
        chk("R3 count 8O zero", capq.size(), 1);
        if (capq.size() > 0) chk("R3 zero data odd parity", capq[0], {8'h00, 3'b000});

        // R4/R6: stop low for one bit then mark -> framing error only
        set_cfg(2'd3, 0, 0); capq.delete();
        send_char(8'h3C, 8, 0, 1'b0); hold(1'b1, 14);
        chk("R6 count framing only", capq.size(), 1);
        if (capq.size() > 0) chk("R4 framing word", capq[0], {8'h3C, 3'b010});

        // R5/R8: break begins mid-character and lasts long
        capq.delete();
        hold(1'b0, 1); hold(1'b1, 1); hold(1'b1, 1); hold(1'b0, 40);
        chk("R5 two entries", capq.size(), 2);
        if (capq.size() > 1) begin
            chk("R5 damaged char", capq[0], {8'h03, 3'b010});
            chk("R5 break char", capq[1], {8'h00, 3'b001});
        end
        chk("R8 no entry while low", capq.size(), 2);
        hold(1'b1, 2);
        capq.delete();
        send_char(8'h81, 8, 0, 1'b1); hold(1'b1, 2);
        chk("R8 count after mark", capq.size(), 1);
        if (capq.size() > 0) chk("R8 frame after mark", capq[0], {8'h81, 3'b000});

        // R6: break shorter than a full character time after the damaged one
        capq.delete();
        hold(1'b0, 1); hold(1'b1, 1); hold(1'b1, 1); hold(1'b0, 12); hold(1'b1, 14);
        chk("R6 short break count", capq.size(), 1);
        if (capq.size() > 0) chk("R6 short break word", capq[0], {8'h03, 3'b010});

        // R7/R8: break from start bit, held long
        set_cfg(2'd1, 1, 1); capq.delete();
        hold(1'b0, 30);
        chk("R7 single break entry", capq.size(), 1);
        if (capq.size() > 0) chk("R7 break word", capq[0], {8'h00, 3'b001});
        hold(1'b1, 2);
        chk("R8 nothing on mark", capq.size(), 1);

        // R1: false start glitch of 4 ticks
        set_cfg(2'd3, 0, 0); capq.delete();
        rx_in = 1'b0; repeat (16) @(negedge clk);
        hold(1'b1, 3);
        chk("R1 false start no word", capq.size(), 0);
        send_char(8'h7E, 8, 0, 1'b1); hold(1'b1, 2);
        chk("R1 count after glitch", capq.size(), 1);
        if (capq.size() > 0) chk("R1 frame after glitch", capq[0], {8'h7E, 3'b000});

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule